// File: doc/BRIEF.md
# Interleaved Image Selector and Section Walker

The block sits behind an expander that delivers a combined configuration stream one byte at a time. The combined stream carries several images. They are cut into fixed-size chunks and sent in strict rotation: a chunk of image 0, then a chunk of image 1, and so on, wrapping back to image 0. The block consumes every byte it is offered while it is active. It keeps only the bytes that belong to the image picked by `img_sel`, and it throws away the rest without showing them.

Parsing of the kept bytes runs in three stages:

1. The first thirteen kept bytes must match a fixed signature.
2. The block then walks tagged sections. Each section is a one-byte tag, a big-endian length, and that many content bytes. The walk continues until the section named by `req_tag` turns up.
3. When that section is found, the block latches its length and passes its content bytes out. When the content has been sent, or when a parse fault occurs, the block stops taking bytes until the next `start` pulse.

A `start` pulse latches the image index and the requested tag. It clears every flag and counter, whatever state the block is in.

Top module: `ibs_parser`

## Requirements
- R1: After reset the outputs are as follows: `in_ready`, `out_valid`, `hdr_ok`, `found` and `error` are 0, and `sect_len` is 0.
- R2: Counting the bytes accepted since `start` from 0, byte k belongs to image (k / CHUNK) mod NUM_IMG. A byte is accepted when `in_valid` and `in_ready` are both high. While the block is active it accepts bytes of every image. Only bytes of image `img_sel` are parsed or output, so the number of combined bytes consumed follows from the number of kept bytes.
- R3: The first 13 kept bytes are compared with 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. If all 13 match, `hdr_ok` rises. On the first mismatch, `error` rises, `hdr_ok` stays 0, and that mismatching byte is the last byte consumed.
- R4: A section tag of 0x61 to 0x64 ('a' to 'd') is followed by a 2-byte big-endian length. Tag 0x65 ('e') is followed by a 4-byte big-endian length.
- R5: A tag byte outside 0x61 to 0x65 sets `error`, and no further byte is consumed.
- R6: A section other than 'e' whose length is above 255 sets `error`, even when it is the requested tag. A length of exactly 255 is accepted.
- R7: After the signature, the block counts header bytes: tag, length and skipped content bytes. The count is checked before a tag is read and before each skipped content byte is consumed. If the count has reached 100 at either point, `error` rises without consuming another byte.
- R8: When the tag equals `req_tag`, `found` rises and `sect_len` holds the length. The block then outputs exactly `sect_len` content bytes on `out_valid`/`out_data`, and after that `in_ready` falls. With a length of 0 it stops at once.
- R9: A `start` pulse clears `hdr_ok`, `found`, `error`, the byte count and the header count. One cycle later the block begins a new parse.
- R10: `found` and `error` are never high together. Once either is set, it and `sect_len` stay unchanged and `in_ready` stays low until the next `start`, except that `in_ready` stays high while the payload is still being passed out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new parse; latches `img_sel` and `req_tag` |
| img_sel | input | IDX_W | Index of the image to keep |
| req_tag | input | 8 | ASCII tag of the section to find |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte of the combined stream |
| in_ready | output | 1 | Block accepts the byte on this cycle |
| out_valid | output | 1 | Payload byte of the found section present |
| out_data | output | 8 | Payload byte |
| hdr_ok | output | 1 | Signature matched |
| found | output | 1 | Requested section located |
| error | output | 1 | Signature, tag, length or search-limit fault |
| sect_len | output | 32 | Length of the found section |

## Verification
A chunk counter that wraps one byte early or late shifts which bytes are kept. That shows within one chunk as a wrong signature verdict, or as a different total of consumed bytes when the parse stops. A header count or length accumulator that is off by one moves the point where `error` or `found` rises, and it changes the consumed-byte total in the same case. A payload counter that is wrong shows as one byte too many or too few on `out_valid` before `in_ready` falls. Sweeping every image index against every requested tag exposes each of these by the end of a single parse.

// File: rtl/ibs_pkg.sv
package ibs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SIG, ST_TAG, ST_LEN, ST_SKIP, ST_PAY, ST_DONE
  } walk_st_t;

  localparam int SIG_LEN = 13;
  localparam logic [7:0] TAG_LO   = 8'h61;
  localparam logic [7:0] TAG_WIDE = 8'h65;

  // expected signature byte at position i
  function automatic logic [7:0] sig_byte(input logic [3:0] i);
    case (i)
      4'd0, 4'd10, 4'd11: sig_byte = 8'h00;
      4'd1:               sig_byte = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8: sig_byte = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9: sig_byte = 8'hF0;
      default:            sig_byte = 8'h01;
    endcase
  endfunction

  function automatic logic tag_legal(input logic [7:0] t);
    tag_legal = (t >= TAG_LO) && (t <= TAG_WIDE);
  endfunction

  // number of length bytes following a tag
  function automatic logic [2:0] len_bytes(input logic [7:0] t);
    len_bytes = (t == TAG_WIDE) ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/ibs_lane_track.sv
module ibs_lane_track #(
  parameter int NUM_IMG = 2,
  parameter int CHUNK   = 288,
  localparam int OFF_W  = $clog2(CHUNK),
  localparam int IDX_W  = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [IDX_W-1:0] sel,
  input  logic             step,
  output logic             own
);

  logic [OFF_W-1:0] off_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      idx_q <= '0;
      sel_q <= '0;
    end else if (clear) begin
      off_q <= '0;
      idx_q <= '0;
      sel_q <= sel;
    end else if (step) begin
      if (off_q == OFF_W'(CHUNK - 1)) begin
        off_q <= '0;
        idx_q <= (idx_q == IDX_W'(NUM_IMG - 1)) ? '0 : idx_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  assign own = (idx_q == sel_q);

endmodule

// File: rtl/ibs_walker.sv
module ibs_walker
  import ibs_pkg::*;
#(
  parameter int LIMIT = 100,
  localparam int HB_W = $clog2(LIMIT + 6)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  req_tag,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        own,
  output logic        in_ready,
  output logic        fire,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        hdr_ok,
  output logic        found,
  output logic        error,
  output logic [31:0] sect_len,
  output logic        ev_sig_bad,
  output logic        ev_limit
);

  walk_st_t    st;
  logic [3:0]  sig_idx;
  logic [HB_W-1:0] hb;
  logic [7:0]  tag_q, req_q;
  logic [2:0]  lcnt;
  logic [31:0] acc, rem;

  logic        limit_hit, take, len_last, ev_bad_tag, ev_too_long, ev_match;
  logic [31:0] acc_nx;

  always_comb begin
    limit_hit   = hb >= HB_W'(LIMIT);
    ev_limit    = (st == ST_TAG || st == ST_SKIP) && limit_hit;
    in_ready    = (st == ST_SIG) || (st == ST_LEN) || (st == ST_PAY) ||
                  ((st == ST_TAG || st == ST_SKIP) && !limit_hit);
    fire        = in_valid && in_ready;
    take        = fire && own;
    acc_nx      = {acc[23:0], in_data};
    ev_sig_bad  = take && (st == ST_SIG) && (in_data != sig_byte(sig_idx));
    ev_bad_tag  = take && (st == ST_TAG) && !tag_legal(in_data);
    len_last    = take && (st == ST_LEN) && (lcnt == 3'd1);
    ev_too_long = len_last && (tag_q != TAG_WIDE) && (acc_nx > 32'd255);
    ev_match    = len_last && !ev_too_long && (tag_q == req_q);
    out_valid   = take && (st == ST_PAY);
    out_data    = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sig_idx <= '0; hb <= '0; tag_q <= '0; req_q <= '0;
      lcnt <= '0; acc <= '0; rem <= '0;
      hdr_ok <= 1'b0; found <= 1'b0; error <= 1'b0; sect_len <= '0;
    end else if (start) begin
      st <= ST_SIG; sig_idx <= '0; hb <= '0; req_q <= req_tag;
      hdr_ok <= 1'b0; found <= 1'b0; error <= 1'b0; sect_len <= '0;
    end else begin
      case (st)
        ST_SIG: if (take) begin
          if (ev_sig_bad) begin
            error <= 1'b1; st <= ST_DONE;
          end else if (sig_idx == 4'(SIG_LEN - 1)) begin
            hdr_ok <= 1'b1; st <= ST_TAG;
          end else begin
            sig_idx <= sig_idx + 1'b1;
          end
        end
        ST_TAG: if (ev_limit) begin
          error <= 1'b1; st <= ST_DONE;
        end else if (take) begin
          hb <= hb + 1'b1;
          if (ev_bad_tag) begin
            error <= 1'b1; st <= ST_DONE;
          end else begin
            tag_q <= in_data; lcnt <= len_bytes(in_data); acc <= '0; st <= ST_LEN;
          end
        end
        ST_LEN: if (take) begin
          hb <= hb + 1'b1; acc <= acc_nx; lcnt <= lcnt - 1'b1;
          if (len_last) begin
            if (ev_too_long) begin
              error <= 1'b1; st <= ST_DONE;
            end else if (ev_match) begin
              found <= 1'b1; sect_len <= acc_nx; rem <= acc_nx;
              st <= (acc_nx == 32'd0) ? ST_DONE : ST_PAY;
            end else if (acc_nx == 32'd0) begin
              st <= ST_TAG;
            end else begin
              rem <= acc_nx; st <= ST_SKIP;
            end
          end
        end
        ST_SKIP: if (ev_limit) begin
          error <= 1'b1; st <= ST_DONE;
        end else if (take) begin
          hb <= hb + 1'b1; rem <= rem - 1'b1;
          if (rem == 32'd1) st <= ST_TAG;
        end
        ST_PAY: if (take) begin
          rem <= rem - 1'b1;
          if (rem == 32'd1) st <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ibs_parser.sv
module ibs_parser #(
  parameter int NUM_IMG = 2,
  parameter int CHUNK   = 288,
  parameter int LIMIT   = 100,
  localparam int IDX_W  = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] img_sel,
  input  logic [7:0]       req_tag,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             hdr_ok,
  output logic             found,
  output logic             error,
  output logic [31:0]      sect_len
);

  logic fire, own, ev_sig_bad, ev_limit;

  ibs_lane_track #(.NUM_IMG(NUM_IMG), .CHUNK(CHUNK)) lane_i (
    .clk(clk), .rst_n(rst_n), .clear(start), .sel(img_sel),
    .step(fire), .own(own)
  );

  ibs_walker #(.LIMIT(LIMIT)) walk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_tag(req_tag),
    .in_valid(in_valid), .in_data(in_data), .own(own),
    .in_ready(in_ready), .fire(fire), .out_valid(out_valid), .out_data(out_data),
    .hdr_ok(hdr_ok), .found(found), .error(error), .sect_len(sect_len),
    .ev_sig_bad(ev_sig_bad), .ev_limit(ev_limit)
  );

endmodule

// File: rtl/ibs_parser_chk.sv
module ibs_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_ready,
  input logic        own,
  input logic        out_valid,
  input logic        hdr_ok,
  input logic        found,
  input logic        error,
  input logic [31:0] sect_len,
  input logic        ev_sig_bad,
  input logic        ev_limit
);

  assert_pay_after_found_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> found);

  assert_drop_foreign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> own);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && error));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  assert_err_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !in_ready);

  assert_len_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !start) |=> (found && $stable(sect_len)));

  assert_sig_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sig_bad && !start) |=> (error && !hdr_ok));

  assert_limit_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_limit && !start) |=> (error && !in_ready));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!found && !error && !hdr_ok));

endmodule

bind ibs_parser ibs_parser_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready), .own(own),
  .out_valid(out_valid), .hdr_ok(hdr_ok), .found(found), .error(error),
  .sect_len(sect_len), .ev_sig_bad(ev_sig_bad), .ev_limit(ev_limit)
);

// File: tb/ibs_parser_tb_top.sv
module ibs_parser_tb_top;
  localparam int N  = 3;
  localparam int CH = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [1:0] img_sel = '0;
  logic [7:0] req_tag = '0, in_data = '0;
  logic in_ready, out_valid, hdr_ok, found, error;
  logic [7:0] out_data;
  logic [31:0] sect_len;

  int total = 0, bad = 0;
  logic [7:0] img [0:1023];
  int ilen;
  logic [7:0] cap [0:1023];
  bit m_found, m_err, m_hdr;
  int m_len, m_used, m_pay;

  localparam logic [7:0] SIGV [0:12] =
    '{8'h00,8'h09,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h00,8'h00,8'h01};

  ibs_parser #(.NUM_IMG(N), .CHUNK(CH), .LIMIT(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_sel(img_sel), .req_tag(req_tag),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .hdr_ok(hdr_ok),
    .found(found), .error(error), .sect_len(sect_len)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic img_clear();
    for (int i = 0; i < 1024; i++) img[i] = 8'hEE;
    ilen = 0;
  endtask
  task automatic put(input logic [7:0] b);
    img[ilen] = b; ilen++;
  endtask
  task automatic put_sig();
    for (int i = 0; i < 13; i++) put(SIGV[i]);
  endtask
  task automatic put_sect(input logic [7:0] t, input int len);
    put(t);
    if (t == 8'h65) begin put(len[31:24]); put(len[23:16]); end
    put(len[15:8]); put(len[7:0]);
    for (int q = 0; q < len; q++) put(8'(8'h30 + q * 7 + t));
  endtask

  // behavioural reading of the requirements
  task automatic model(input logic [7:0] rq);
    int u, nb, n; logic [31:0] L; logic [7:0] t;
    m_found = 0; m_err = 0; m_hdr = 0; m_len = 0; m_pay = 0;
    for (int i = 0; i < 13; i++)
      if (img[i] != SIGV[i]) begin m_err = 1; m_used = i + 1; return; end
    m_hdr = 1; u = 13; nb = 0;
    forever begin
      if (nb >= 100) begin m_err = 1; m_used = u; return; end
      t = img[u]; u++; nb++;
      if (t < 8'h61 || t > 8'h65) begin m_err = 1; m_used = u; return; end
      n = (t == 8'h65) ? 4 : 2; L = 0;
      for (int q = 0; q < n; q++) begin L = {L[23:0], img[u]}; u++; end
      nb += n;
      if (t != 8'h65 && L > 255) begin m_err = 1; m_used = u; return; end
      if (t == rq) begin
        m_found = 1; m_len = int'(L); m_pay = u; u += int'(L); m_used = u; return;
      end
      for (int q = 0; q < int'(L) && nb < 100; q++) begin u++; nb++; end
    end
  endtask

  function automatic logic [7:0] sbyte(input int k, input int sel);
    int j;
    if ((k / CH) % N == sel) begin
      j = (k / (CH * N)) * CH + k % CH;
      return (j < 1024) ? img[j] : 8'hEE;
    end
    return 8'h5A ^ k[7:0];
  endfunction

  task automatic run_case(input int sel, input logic [7:0] rq, input string etag);
    int k, nout, cyc, expk;
    logic [31:0] len_seen;
    model(rq);
    @(negedge clk);
    img_sel = 2'(sel); req_tag = rq; start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0; #1;
    chk(!found && !error && !hdr_ok, "R9", "flags after start", {found, error, hdr_ok}, 0);
    k = 0; nout = 0; cyc = 0;
    forever begin
      in_valid = (cyc % 5) != 3;
      in_data = sbyte(k, sel);
      #1;
      if (!in_ready && (found || error)) break;
      if (out_valid) begin cap[nout] = out_data; nout++; end
      if (in_valid && in_ready) k++;
      cyc++;
      if (cyc > 8000) break;
      @(negedge clk);
    end
    expk = (m_used - 1) / CH * CH * N + sel * CH + (m_used - 1) % CH + 1;
    chk(hdr_ok == m_hdr, "R3", "hdr_ok", hdr_ok, m_hdr);
    chk(error == m_err, etag, "error", error, m_err);
    chk(found == m_found, etag, "found", found, m_found);
    chk(k == expk, "R2", "combined bytes consumed", k, expk);
    if (m_found) chk(sect_len == 32'(m_len), "R4", "sect_len", sect_len, m_len);
    chk(nout == (m_found ? m_len : 0), "R8", "payload count", nout, m_found ? m_len : 0);
    for (int i = 0; i < nout && i < m_len; i++)
      if (cap[i] != img[m_pay + i]) begin
        chk(0, "R8", "payload byte", cap[i], img[m_pay + i]); break;
      end
    len_seen = sect_len;
    for (int w = 0; w < 3; w++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'h61; #1;
      chk(!in_ready && !out_valid && found == m_found && error == m_err
          && sect_len == len_seen, "R10", "hold after stop", in_ready, 0);
    end
    in_valid = 1'b0;
  endtask

  task automatic std_image();
    img_clear(); put_sig();
    put_sect(8'h61, 3); put_sect(8'h62, 4); put_sect(8'h63, 2);
    put_sect(8'h64, 1); put_sect(8'h65, 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog expired: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk(!in_ready && !out_valid && !hdr_ok && !found && !error && sect_len == 0,
        "R1", "reset outputs", {in_ready, out_valid, hdr_ok, found, error}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!in_ready && !found && !error, "R1", "idle after reset", in_ready, 0);

    // sweep image index against every tag, plus an absent one
    std_image();
    for (int s = 0; s < N; s++)
      for (int t = 8'h61; t <= 8'h66; t++)
        run_case(s, 8'(t), (t == 8'h66) ? "R5" : "R8");

    // signature mismatch at several positions
    for (int p = 0; p < 13; p += 6) begin
      std_image(); img[p] = img[p] ^ 8'h40;
      run_case(p % N, 8'h62, "R3");
    end

    // illegal tag after one section
    img_clear(); put_sig(); put_sect(8'h61, 2); put(8'h7A);
    run_case(1, 8'h62, "R5");

    // length 256 on a short-length tag, and 255 accepted
    img_clear(); put_sig(); put_sect(8'h61, 1); put_sect(8'h63, 256);
    run_case(2, 8'h63, "R6");
    img_clear(); put_sig(); put_sect(8'h62, 255);
    run_case(0, 8'h62, "R6");

    // limit reached while skipping content
    img_clear(); put_sig();
    for (int i = 0; i < 6; i++) put_sect(8'h61, 20);
    put_sect(8'h62, 2);
    run_case(1, 8'h62, "R7");

    // limit reached exactly at a section boundary
    img_clear(); put_sig();
    for (int i = 0; i < 5; i++) put_sect(8'h61, 17);
    put_sect(8'h62, 2);
    run_case(2, 8'h62, "R7");

    // wide length section crossing many chunks
    img_clear(); put_sig(); put_sect(8'h65, 288);
    run_case(1, 8'h65, "R4");

    // zero-length sections
    img_clear(); put_sig(); put_sect(8'h61, 0); put_sect(8'h62, 2);
    run_case(0, 8'h62, "R8");
    run_case(2, 8'h61, "R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule